// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Controller

This block is the private cache controller that sits between one processor and the shared, atomic system bus of a small shared-memory multiprocessor. It is direct-mapped, and each line holds a single data word. Every line is either Valid or Invalid. Invalid also stands for "not present". Reads that hit are answered locally. Reads that miss fetch the word over the bus and install it. Every write goes out on the bus to memory. A write that misses leaves the cache untouched, and a write that hits also refreshes the local copy.

Coherence is kept by snooping. Each cache watches every bus command. When another cache writes an address that this cache holds Valid, the local line is dropped, so the next read misses and fetches the fresh value from memory. The bus is atomic, so writes and the invalidations they cause take effect in the order the bus grants them. A bus transaction runs through three phases: arbitration (request held until grant), a one-cycle command/address phase, and a data phase that ends with a completion pulse from memory.

The processor side is a valid/ready stream. A request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` stays low from the acceptance of a request that needs the bus until that request completes, which back-pressures the processor. Results come back as a one-cycle strobe with no ready of their own, so the processor must always be able to take them.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `bus_req`, `bus_cmd_valid` and `cpu_rsp_valid` are low. The first read of any address therefore misses.
- R2: A read whose line is Invalid, or whose tag differs, raises `bus_req` in the cycle after acceptance. One cycle after the grant it drives a command with `bus_cmd_write`=0 (bus read) and the request address. In the cycle after `bus_done` it pulses `cpu_rsp_valid` with the `bus_rdata` value and leaves the line Valid with that word.
- R3: A read that hits a Valid line with a matching tag pulses `cpu_rsp_valid` with the stored word in the cycle after acceptance and raises no `bus_req`.
- R4: Every write raises `bus_req` in the cycle after acceptance. It drives a command with `bus_cmd_write`=1 (bus write) carrying the address and the data, and pulses `cpu_rsp_valid` in the cycle after `bus_done`, with `cpu_rsp_rdata` equal to the written data.
- R5: A write that misses allocates nothing. The line at that index keeps its previous contents and state.
- R6: A write that hits updates the local word when it completes, and the line stays Valid. A later read hits and returns the new word.
- R7: A snooped command with `snp_valid`=1, `snp_write`=1 and `snp_src` different from `SELF_ID`, whose address matches a Valid line, makes that line Invalid from the next clock edge.
- R8: A snooped bus read (`snp_write`=0), or a snooped bus write whose tag differs from the Valid line at that index, leaves the cache unchanged.
- R9: A snooped bus write whose `snp_src` equals `SELF_ID` never invalidates a line.
- R10: `bus_req` stays high until a cycle with `bus_gnt`. `bus_cmd_valid` is high for exactly the one cycle after the grant. `cpu_req_ready` is low whenever `bus_req` is high.
- R11: The line index is the low log2(`LINES`) address bits and the tag is the rest. A read miss replaces whatever line held that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion strobe |
| cpu_rsp_rdata | output | DATA_W | Read word, or the written word for writes |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Arbitration grant |
| bus_cmd_valid | output | 1 | Command/address phase |
| bus_cmd_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_wdata | output | DATA_W | Write data for bus writes |
| bus_done | input | 1 | Data phase complete |
| bus_rdata | input | DATA_W | Memory data, valid with bus_done |
| snp_valid | input | 1 | Observed bus command valid |
| snp_write | input | 1 | Observed command is a write |
| snp_src | input | ID_W | Identifier of the issuing cache |
| snp_addr | input | ADDR_W | Observed command address |

## Verification
A read hit answers one cycle after acceptance. A request that needs the bus shows `bus_req` one cycle after acceptance, its command one cycle after the grant cycle, and its response one cycle after `bus_done`. A snooped invalidation is visible from the next request onward. The bench drives every input on the falling edge and samples at the next falling edge after the rising edge that should produce each result, so each check lands on the exact cycle the requirement names. Grant and memory latencies are drawn at random, and hit/miss expectations come from a reference mirror of tags, states and memory that the bench updates only from the requirements.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_ARB  = 2'd1,
    CTL_CMD  = 2'd2,
    CTL_WAIT = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/wtc_line_array.sv
module wtc_line_array #(
  parameter int LINES  = 16,
  parameter int IDX_W  = $clog2(LINES),
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              look_valid,
  output logic [TAG_W-1:0]  look_tag,
  output logic [DATA_W-1:0] look_data,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              snp_line_valid,
  output logic [TAG_W-1:0]  snp_line_tag,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [LINES-1:0]  vld_vec;
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : gen_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              sel_wr;
    logic              sel_inv;
    assign sel_wr  = wr_en && (wr_idx == IDX_W'(i));
    assign sel_inv = inv_en && (inv_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else begin
        if (sel_inv) v_q <= 1'b0;
        if (sel_wr) begin
          d_q <= wr_data;
          if (wr_alloc) begin
            v_q <= 1'b1;
            t_q <= wr_tag;
          end
        end
      end
    end

    assign vld_vec[i] = v_q;
    assign tag_arr[i] = t_q;
    assign dat_arr[i] = d_q;
  end

  assign look_valid     = vld_vec[look_idx];
  assign look_tag       = tag_arr[look_idx];
  assign look_data      = dat_arr[look_idx];
  assign snp_line_valid = vld_vec[snp_idx];
  assign snp_line_tag   = tag_arr[snp_idx];
endmodule

// File: rtl/wtc_snoop.sv
module wtc_snoop #(
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = ADDR_W - IDX_W,
  parameter int ID_W    = 2,
  parameter int SELF_ID = 0
) (
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  snp_idx,
  input  logic              line_valid,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              inv_en
);
  logic foreign_write;
  assign snp_idx       = snp_addr[IDX_W-1:0];
  assign foreign_write = snp_valid && snp_write && (snp_src != ID_W'(SELF_ID));
  assign inv_en        = foreign_write && line_valid &&
                         (line_tag == snp_addr[ADDR_W-1:IDX_W]);
endmodule

// File: rtl/wtc_ctl.sv
module wtc_ctl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [IDX_W-1:0]  look_idx,
  input  logic              look_valid,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [DATA_W-1:0] look_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              wr_en,
  output logic              wr_alloc,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  ctl_state_t        st;
  logic              lat_wr;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [ADDR_W-1:0] cur_addr;
  logic              hit, accept, finish;

  assign req_ready = (st == CTL_IDLE);
  assign cur_addr  = req_ready ? req_addr : lat_addr;
  assign look_idx  = cur_addr[IDX_W-1:0];
  // Hit is evaluated against the current line contents, so a write held in
  // arbitration sees any invalidation that landed while it waited.
  assign hit       = look_valid && (look_tag == cur_addr[ADDR_W-1:IDX_W]);
  assign accept    = req_valid && req_ready;
  assign finish    = (st == CTL_WAIT) && bus_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= CTL_IDLE;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        CTL_IDLE: if (accept) begin
          if (!req_write && hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= look_data;
          end else begin
            lat_wr    <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            st        <= CTL_ARB;
          end
        end
        CTL_ARB:  if (bus_gnt) st <= CTL_CMD;
        CTL_CMD:  st <= CTL_WAIT;
        CTL_WAIT: if (bus_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= lat_wr ? lat_wdata : bus_rdata;
          st        <= CTL_IDLE;
        end
        default:  st <= CTL_IDLE;
      endcase
    end
  end

  assign bus_req   = (st == CTL_ARB);
  assign cmd_valid = (st == CTL_CMD);
  assign cmd_write = lat_wr;
  assign cmd_addr  = lat_addr;
  assign cmd_wdata = lat_wdata;

  // Read miss installs the line; write hit refreshes data only.
  assign wr_alloc = !lat_wr;
  assign wr_en    = finish && (!lat_wr || hit);
  assign wr_idx   = lat_addr[IDX_W-1:0];
  assign wr_tag   = lat_addr[ADDR_W-1:IDX_W];
  assign wr_data  = lat_wr ? lat_wdata : bus_rdata;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LINES   = 16,
  parameter int ID_W    = 2,
  parameter int SELF_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic              bus_cmd_write,
  output logic [ADDR_W-1:0] bus_cmd_addr,
  output logic [DATA_W-1:0] bus_cmd_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  look_idx, snp_idx, wr_idx;
  logic              look_valid, snp_line_valid;
  logic [TAG_W-1:0]  look_tag, snp_line_tag, wr_tag;
  logic [DATA_W-1:0] look_data, wr_data;
  logic              wr_en, wr_alloc, inv_en;

  wtc_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready), .req_write(cpu_req_write),
    .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
    .rsp_valid(cpu_rsp_valid), .rsp_rdata(cpu_rsp_rdata),
    .look_idx(look_idx), .look_valid(look_valid), .look_tag(look_tag), .look_data(look_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .cmd_valid(bus_cmd_valid), .cmd_write(bus_cmd_write),
    .cmd_addr(bus_cmd_addr), .cmd_wdata(bus_cmd_wdata),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  wtc_line_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_idx), .look_valid(look_valid), .look_tag(look_tag), .look_data(look_data),
    .snp_idx(snp_idx), .snp_line_valid(snp_line_valid), .snp_line_tag(snp_line_tag),
    .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .inv_en(inv_en), .inv_idx(snp_idx)
  );

  wtc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ID_W(ID_W), .SELF_ID(SELF_ID)) u_snoop (
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_src(snp_src), .snp_addr(snp_addr),
    .snp_idx(snp_idx), .line_valid(snp_line_valid), .line_tag(snp_line_tag),
    .inv_en(inv_en)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_req_valid,
  input logic cpu_req_ready,
  input logic cpu_req_write,
  input logic cpu_rsp_valid,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_cmd_valid,
  input logic bus_done
);
  assert_cmd_after_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> $past(bus_req && bus_gnt));
  assert_cmd_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> !bus_cmd_valid);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_ready);
  assert_write_goes_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_write) |=> bus_req);
  assert_done_responds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && !cpu_req_ready && !bus_req && !bus_cmd_valid) |=> cpu_rsp_valid);
endmodule

bind wt_snoop_cache wtc_checker u_wtc_checker (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_write(cpu_req_write), .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd_valid(bus_cmd_valid), .bus_done(bus_done)
);

// File: tb/wt_snoop_cache_bench.sv
module wt_snoop_cache_bench;
  localparam int AW = 6, DW = 16, NL = 4, IW = 2, ME = 1, PEER = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic bus_req, cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic gnt = 0, done = 0;
  logic [DW-1:0] rdata = '0;
  logic s_valid = 0, s_write = 0;
  logic [IW-1:0] s_src = '0;
  logic [AW-1:0] s_addr = '0;

  int tests = 0, fails = 0, cyc = 0;

  logic          mv [NL];
  logic [3:0]    mt [NL];
  logic [DW-1:0] md [NL];
  logic [DW-1:0] mem [64];

  always #5 clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .ID_W(IW), .SELF_ID(ME)) u_wt_snoop_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_valid), .cpu_req_ready(req_ready), .cpu_req_write(req_write),
    .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(rsp_valid), .cpu_rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_gnt(gnt), .bus_cmd_valid(cmd_valid), .bus_cmd_write(cmd_write),
    .bus_cmd_addr(cmd_addr), .bus_cmd_wdata(cmd_wdata), .bus_done(done), .bus_rdata(rdata),
    .snp_valid(s_valid), .snp_write(s_write), .snp_src(s_src), .snp_addr(s_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=%0d expected<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    return mv[a[1:0]] && (mt[a[1:0]] == a[5:2]);
  endfunction

  // One processor request with the bench acting as arbiter and memory.
  task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input string rq);
    bit hit = model_hit(a);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (!wr && hit) begin
      check(rsp_valid && !bus_req, rq, "hit strobe/no bus", {rsp_valid, bus_req}, 32'h2);
      check(rsp_rdata == md[a[1:0]], rq, "hit data", rsp_rdata, md[a[1:0]]);
      return;
    end
    check(bus_req && !rsp_valid, rq, "bus request after accept", {bus_req, rsp_valid}, 32'h2);
    check(!req_ready, "R10", "ready low while busy", req_ready, 0);
    repeat ($urandom % 4) begin
      @(negedge clk);
      check(bus_req && !cmd_valid, "R10", "request held without grant", {bus_req, cmd_valid}, 32'h2);
    end
    gnt = 1;
    @(negedge clk);
    gnt = 0;
    check(cmd_valid && cmd_write == wr && cmd_addr == a, rq, "command phase",
          {cmd_valid, cmd_write, cmd_addr}, {1'b1, wr, a});
    if (wr) check(cmd_wdata == d, "R4", "command write data", cmd_wdata, d);
    s_valid = 1; s_write = wr; s_src = IW'(ME); s_addr = a;
    @(negedge clk);
    s_valid = 0;
    check(!cmd_valid && !bus_req, "R10", "command lasts one cycle", {cmd_valid, bus_req}, 0);
    repeat ($urandom % 3) @(negedge clk);
    if (wr) mem[a] = d;
    done = 1; rdata = mem[a];
    @(negedge clk);
    done = 0;
    check(rsp_valid && req_ready, rq, "completion strobe", {rsp_valid, req_ready}, 32'h3);
    check(rsp_rdata == mem[a], rq, "response data", rsp_rdata, mem[a]);
    if (!wr) begin
      mv[a[1:0]] = 1; mt[a[1:0]] = a[5:2]; md[a[1:0]] = mem[a];
    end else if (hit) begin
      md[a[1:0]] = d;
    end
  endtask

  task automatic peer_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    s_valid = 1; s_write = wr; s_src = IW'(PEER); s_addr = a;
    if (wr) begin
      mem[a] = d;
      if (model_hit(a)) mv[a[1:0]] = 0;
    end
    @(negedge clk);
    s_valid = 0;
  endtask

  function automatic string auto_tag(input bit wr, input logic [AW-1:0] a);
    if (wr) return "R4";
    return model_hit(a) ? "R3" : "R2";
  endfunction

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) mem[i] = DW'(i * 37 + 5);
    for (int i = 0; i < NL; i++) begin mv[i] = 0; mt[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !bus_req && !cmd_valid && !rsp_valid, "R1", "reset outputs",
          {req_ready, bus_req, cmd_valid, rsp_valid}, 32'h8);
    cpu_op(0, 6'h05, 0, "R1");        // cold miss after reset
    cpu_op(0, 6'h05, 0, "R3");        // hit
    cpu_op(1, 6'h05, 16'hBEEF, "R6"); // write hit, own echo on snoop
    cpu_op(0, 6'h05, 0, "R9");        // still hits: own write ignored
    cpu_op(1, 6'h09, 16'h1234, "R5"); // write miss, same index
    cpu_op(0, 6'h05, 0, "R5");        // old line untouched
    cpu_op(0, 6'h09, 0, "R11");       // conflict miss replaces line
    cpu_op(0, 6'h05, 0, "R11");       // previous tag now misses
    peer_op(0, 6'h05, 0);
    cpu_op(0, 6'h05, 0, "R8");        // peer read: still hits
    peer_op(1, 6'h0D, 16'h5555);
    cpu_op(0, 6'h05, 0, "R8");        // peer write, other tag: still hits
    peer_op(1, 6'h05, 16'hA5A5);
    cpu_op(0, 6'h05, 0, "R7");        // invalidated: miss, new memory value
    for (int n = 0; n < 300; n++) begin
      int op = $urandom % 5;
      logic [AW-1:0] a = AW'($urandom % 16);
      logic [DW-1:0] d = DW'($urandom);
      if (op == 4) peer_op($urandom % 2 == 0, a, d);
      else cpu_op(op == 3, a, d, auto_tag(op == 3, a));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule